// File: doc/BRIEF.md
# Double-Sampled Sparse Prefix Adder

This block adds two 64-bit operands and a carry-in and returns a 64-bit sum and a carry-out. The carry network is a divide-and-conquer parallel prefix tree that works on 4-bit groups. It resolves only the carries at group boundaries. Inside each group, a short segment computes the sum for both possible incoming carries and then selects one of them.

A soft error is detected by taking the same combinational sum twice within one clock cycle. A main strobe loads the result register. A late strobe loads a shadow register a fixed interval afterwards. On the next clock, the two words are XORed and reduced through three levels of 4-input XOR cells. The outcome is a registered error flag.

A `fault_mask` input is XORed onto the sum on the way into the shadow register only. This lets a test inject a transient that upsets bits between the two samples. In a single-clock model both strobes act as capture enables on the clock edge.

Top module: `dsa_adder`

## Requirements
- R1: When `strobe_main` is high at a clock edge, `sum` and `cout` show, after that edge, the 65-bit value `a + b + cin` taken at that edge. `cout` is bit 64 of that value.
- R2: When `strobe_main` is low at an edge, `sum` and `cout` keep their previous values, whatever the operands are.
- R3: Carry propagation spans every group boundary. For example, all-ones plus zero with `cin`=1 gives `sum`=0 and `cout`=1.
- R4: When `strobe_late` is high at an edge, the shadow register loads `sum_comb ^ fault_mask`. At the next edge, `err` becomes the XOR-reduction (odd parity) of the main word XOR the shadow word.
- R5: With both strobes high in the same cycle and a mask of odd weight, `err` is high for exactly the one cycle that follows the next edge.
- R6: With both strobes high in the same cycle and a mask of zero or even weight, `err` stays low.
- R7: If `strobe_late` is low at an edge, `err` is low after the edge that follows, whatever `fault_mask` is.
- R8: `fault_mask` never changes `sum` or `cout`.
- R9: A synchronous active-high `rst` clears `sum`, `cout`, `err` and the pending compare. All three outputs read zero after a reset edge.
- R10: A late strobe alone compares the new shadow word against the held main word. After the next edge, `err` equals the parity of held sum XOR new sum XOR mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in, merged into group 0 generate |
| strobe_main | input | 1 | Capture enable of the result register |
| strobe_late | input | 1 | Capture enable of the shadow register |
| fault_mask | input | WIDTH | Transient injection onto the shadow sample |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry-out (final group carry) |
| err | output | 1 | Registered mismatch flag |

## Verification
The bench builds the block with its default 64-bit width and 4-bit groups. These give 16 groups, a four-level prefix tree and a three-level XOR reduction with no padding. At these values, all-ones operands carry across every group boundary and through the carry-out.

Masks of weight 1, 3, 63, 2 and 64 probe the parity limit of the compare. Held-main and late-only cycles reach the cases where the two samples come from different operands.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    localparam int unsigned DSA_WIDTH_DEF = 64;
    localparam int unsigned DSA_GRP_DEF   = 4;

    // number of 4:1 reduction levels needed for n inputs
    function automatic int unsigned clog4(input int unsigned n);
        int unsigned lv;
        int unsigned cap;
        lv  = 0;
        cap = 1;
        while (cap < n) begin
            cap = cap * 4;
            lv  = lv + 1;
        end
        return lv;
    endfunction

    function automatic logic xor4(input logic [3:0] v);
        return v[0] ^ v[1] ^ v[2] ^ v[3];
    endfunction

endpackage

// File: rtl/dsa_group_pg.sv
module dsa_group_pg #(
    parameter int unsigned GRP = 4
) (
    input  logic [GRP-1:0] a,
    input  logic [GRP-1:0] b,
    output logic           g,
    output logic           p
);
    always_comb begin
        logic gacc;
        gacc = 1'b0;
        for (int i = 0; i < int'(GRP); i++) begin
            gacc = (a[i] & b[i]) | ((a[i] ^ b[i]) & gacc);
        end
        g = gacc;
        p = &(a ^ b);
    end
endmodule

// File: rtl/dsa_sklansky.sv
module dsa_sklansky #(
    parameter int unsigned NG = 16
) (
    input  logic [NG-1:0] g_in,
    input  logic [NG-1:0] p_in,
    output logic [NG-1:0] c_out
);
    localparam int unsigned LV = (NG > 1) ? $clog2(NG) : 1;

    logic [NG-1:0] gl [LV+1];
    logic [NG-1:0] pl [LV+1];

    assign gl[0] = g_in;
    assign pl[0] = p_in;

    for (genvar lv = 0; lv < int'(LV); lv++) begin : g_lvl
        for (genvar i = 0; i < int'(NG); i++) begin : g_node
            if (((i >> lv) & 1) == 1) begin : g_merge
                localparam int J = ((i >> lv) << lv) - 1;
                assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][J]);
                assign pl[lv+1][i] = pl[lv][i] & pl[lv][J];
            end else begin : g_pass
                assign gl[lv+1][i] = gl[lv][i];
                assign pl[lv+1][i] = pl[lv][i];
            end
        end
    end

    assign c_out = gl[LV];
endmodule

// File: rtl/dsa_group_sum.sv
module dsa_group_sum #(
    parameter int unsigned GRP = 4
) (
    input  logic [GRP-1:0] a,
    input  logic [GRP-1:0] b,
    input  logic           ci,
    output logic [GRP-1:0] s
);
    logic [GRP-1:0] s0;
    logic [GRP-1:0] s1;

    always_comb begin
        logic c0;
        logic c1;
        c0 = 1'b0;
        c1 = 1'b1;
        for (int i = 0; i < int'(GRP); i++) begin
            s0[i] = a[i] ^ b[i] ^ c0;
            s1[i] = a[i] ^ b[i] ^ c1;
            c0 = (a[i] & b[i]) | ((a[i] ^ b[i]) & c0);
            c1 = (a[i] & b[i]) | ((a[i] ^ b[i]) & c1);
        end
    end

    assign s = ci ? s1 : s0;
endmodule

// File: rtl/dsa_xor4_tree.sv
module dsa_xor4_tree
    import dsa_pkg::*;
#(
    parameter int unsigned N = 64
) (
    input  logic [N-1:0] diff,
    output logic         odd
);
    localparam int unsigned LEVELS = (clog4(N) == 0) ? 1 : clog4(N);
    localparam int unsigned PADW   = 4 ** LEVELS;

    always_comb begin
        logic [PADW-1:0] cur;
        logic [PADW-1:0] nxt;
        cur = '0;
        cur[N-1:0] = diff;
        for (int lv = 0; lv < int'(LEVELS); lv++) begin
            nxt = '0;
            for (int i = 0; i < int'(PADW / 4); i++) begin
                nxt[i] = xor4(cur[4*i +: 4]);
            end
            cur = nxt;
        end
        odd = cur[0];
    end
endmodule

// File: rtl/dsa_adder.sv
module dsa_adder
    import dsa_pkg::*;
#(
    parameter int unsigned WIDTH = DSA_WIDTH_DEF,
    parameter int unsigned GRP   = DSA_GRP_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             strobe_main,
    input  logic             strobe_late,
    input  logic [WIDTH-1:0] fault_mask,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             err
);
    localparam int unsigned NG = WIDTH / GRP;

    typedef struct packed {
        logic [WIDTH-1:0] main;
        logic [WIDTH-1:0] shadow;
        logic             cout;
        logic             pend;
        logic             err;
    } dsa_state_t;

    dsa_state_t st_d, st_q;

    logic [NG-1:0]    grp_g;
    logic [NG-1:0]    grp_p;
    logic [NG-1:0]    grp_g_cin;
    logic [NG-1:0]    grp_c;
    logic [NG-1:0]    grp_ci;
    logic [WIDTH-1:0] sum_comb;
    logic             mismatch_odd;

    for (genvar k = 0; k < int'(NG); k++) begin : g_grp
        dsa_group_pg #(.GRP(GRP)) u_pg (
            .a (a[k*GRP +: GRP]),
            .b (b[k*GRP +: GRP]),
            .g (grp_g[k]),
            .p (grp_p[k])
        );
        if (k == 0) begin : g_first
            assign grp_g_cin[k] = grp_g[k] | (grp_p[k] & cin);
            assign grp_ci[k]    = cin;
        end else begin : g_rest
            assign grp_g_cin[k] = grp_g[k];
            assign grp_ci[k]    = grp_c[k-1];
        end
        dsa_group_sum #(.GRP(GRP)) u_sum (
            .a  (a[k*GRP +: GRP]),
            .b  (b[k*GRP +: GRP]),
            .ci (grp_ci[k]),
            .s  (sum_comb[k*GRP +: GRP])
        );
    end

    dsa_sklansky #(.NG(NG)) u_tree (
        .g_in  (grp_g_cin),
        .p_in  (grp_p),
        .c_out (grp_c)
    );

    dsa_xor4_tree #(.N(WIDTH)) u_cmp (
        .diff (st_q.main ^ st_q.shadow),
        .odd  (mismatch_odd)
    );

    always_comb begin
        st_d = st_q;
        if (strobe_main) begin
            st_d.main = sum_comb;
            st_d.cout = grp_c[NG-1];
        end
        if (strobe_late) begin
            st_d.shadow = sum_comb ^ fault_mask;
        end
        st_d.pend = strobe_late;
        st_d.err  = st_q.pend & mismatch_odd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum  = st_q.main;
    assign cout = st_q.cout;
    assign err  = st_q.err;
endmodule

// File: rtl/dsa_adder_chk.sv
module dsa_adder_chk #(
    parameter int unsigned WIDTH = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic             strobe_main,
    input logic             strobe_late,
    input logic [WIDTH-1:0] fault_mask,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             err
);
    // R1 R3 R8: captured value is the true sum, mask has no effect
    assert_sum_exact_R1: assert property (@(posedge clk) disable iff (rst)
        strobe_main |=> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)}
                                         + {{WIDTH{1'b0}}, $past(cin)})));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !strobe_main |=> ($stable(sum) && $stable(cout)));

    // R5 R6: same-cycle strobes give a flag equal to mask parity
    assert_mask_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe_main && strobe_late) |-> ##2 (err == ^$past(fault_mask, 2)));

    assert_no_window_R7: assert property (@(posedge clk) disable iff (rst)
        !strobe_late |-> ##2 !err);

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (sum == '0 && !cout && !err));
endmodule

bind dsa_adder dsa_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .a           (a),
    .b           (b),
    .cin         (cin),
    .strobe_main (strobe_main),
    .strobe_late (strobe_late),
    .fault_mask  (fault_mask),
    .sum         (sum),
    .cout        (cout),
    .err         (err)
);

// File: tb/dsa_adder_bench.sv
`timescale 1ns/1ps
module dsa_adder_bench;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic         strobe_main = 1'b0;
    logic         strobe_late = 1'b0;
    logic [W-1:0] fault_mask = '0;
    logic [W-1:0] sum;
    logic         cout;
    logic         err;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dsa_adder u_dsa_adder (
        .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
        .strobe_main(strobe_main), .strobe_late(strobe_late),
        .fault_mask(fault_mask), .sum(sum), .cout(cout), .err(err)
    );

    typedef struct {
        logic [W-1:0] sum;
        logic         cout;
        logic         err;
        string        tag;
        string        err_tag;
    } exp_t;

    exp_t exp_q[$];

    // model state derived from the requirements
    logic [W-1:0] m_main = '0;
    logic [W-1:0] m_shadow = '0;
    logic         m_cout = 1'b0;
    logic         m_pend = 1'b0;
    string        m_ptag = "R9";

    task automatic step(input logic r, input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic c, input logic sm, input logic sl,
                        input logic [W-1:0] mk, input string tag);
        logic [W:0] ref_v;
        exp_t it;
        @(negedge clk);
        rst = r; a = av; b = bv; cin = c;
        strobe_main = sm; strobe_late = sl; fault_mask = mk;
        ref_v = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, c};
        it.tag = tag;
        it.err_tag = m_ptag;
        if (r) begin
            it.sum = '0; it.cout = 1'b0; it.err = 1'b0;
            m_main = '0; m_shadow = '0; m_cout = 1'b0; m_pend = 1'b0;
        end else begin
            it.err  = m_pend ? ^(m_main ^ m_shadow) : 1'b0;
            if (sm) begin
                m_main = ref_v[W-1:0];
                m_cout = ref_v[W];
            end
            if (sl) m_shadow = ref_v[W-1:0] ^ mk;
            m_pend = sl;
            it.sum  = m_main;
            it.cout = m_cout;
        end
        m_ptag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: compares each result away from the active edge
    always @(posedge clk) begin
        exp_t it;
        #1;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            checks++;
            if (sum !== it.sum || cout !== it.cout) begin
                failures++;
                $display("FAIL %s sum/cout: got %h/%b expected %h/%b",
                         it.tag, sum, cout, it.sum, it.cout);
            end
            checks++;
            if (err !== it.err) begin
                failures++;
                $display("FAIL %s err: got %b expected %b", it.err_tag, err, it.err);
            end
        end
    end

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [W-1:0] ONES = '1;

    initial begin
        logic [W-1:0] x;
        logic [W-1:0] y;
        // R9 reset state
        step(1, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 5, 7, 1, 1, 1, 1, "R9");
        // R1 plain additions, zero mask (R6 zero weight)
        step(0, 64'd1, 64'd2, 0, 1, 1, 0, "R1");
        step(0, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 1, 1, 1, 0, "R1");
        for (int i = 0; i < 8; i++) begin
            x = {$urandom(), $urandom()};
            y = {$urandom(), $urandom()};
            step(0, x, y, i[0], 1, 1, 0, "R1");
        end
        // R3 full carry chains
        step(0, ONES, 0, 1, 1, 1, 0, "R3");
        step(0, ONES, ONES, 1, 1, 1, 0, "R3");
        step(0, 64'h0000_0000_0000_000f, 64'h1, 0, 1, 1, 0, "R3");
        step(0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 1, 1, 0, "R3");
        // R5 odd masks, R8 sum unaffected
        step(0, 64'd100, 64'd23, 0, 1, 1, 64'h8000_0000_0000_0000, "R5");
        step(0, 64'd7, 64'd9, 0, 0, 0, 0, "R5");
        step(0, 64'hdead, 64'hbeef, 1, 1, 1, 64'h0000_0100_0010_0001, "R8");
        step(0, 64'h42, 64'h24, 0, 1, 1, ONES >> 1, "R5");
        // R6 even masks
        step(0, 64'h1111, 64'h2222, 0, 1, 1, 64'h0000_0000_0000_0011, "R6");
        step(0, 64'h3333, 64'h4444, 1, 1, 1, ONES, "R6");
        // R7 no late strobe, odd mask
        step(0, 64'h5555, 64'h6666, 0, 1, 0, 64'h1, "R7");
        step(0, 64'h5555, 64'h6666, 0, 0, 0, 64'h7, "R7");
        // R2 hold with changing operands
        step(0, 64'h9999, 64'h1, 0, 0, 0, 0, "R2");
        step(0, ONES, ONES, 1, 0, 0, 0, "R2");
        // R10 late-only against held main (R4 compare of differing words)
        step(0, 64'h10, 64'h1, 0, 1, 0, 0, "R10");
        step(0, 64'h10, 64'h2, 0, 0, 1, 0, "R10");
        step(0, 64'h10, 64'h3, 0, 0, 1, 0, "R4");
        step(0, 64'h10, 64'h1, 0, 0, 1, 64'h2, "R4");
        step(0, 0, 0, 0, 0, 0, 0, "R4");
        // R9 mid-run reset drops a pending compare
        step(0, 64'h1, 64'h1, 0, 1, 1, 64'h1, "R9");
        step(1, 64'h1, 64'h1, 0, 1, 1, 64'h1, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        @(posedge clk);
        #2;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule